// File: doc/BRIEF.md
# Edge Timestamping Engine

The engine watches a bank of input lines organised in groups ("slices") of 32. Every clock it compares the synchronised, enabled lines of each slice against the value it last recorded for that slice. When an enabled line has changed, it writes an event record into a FIFO. The record holds a 64-bit timestamp, the slice number, and the slice's previous and current enabled line values. Software XORs the two values to find every line that toggled in that event.

A free-running 64-bit tick counter supplies the timestamps. It starts at zero on reset and advances by one on every clock.

Software reads the record at the head of the FIFO through a 32-bit register port and retires it with a pop command. A level interrupt requests service once the FIFO holds at least a programmable number of records. When several slices change in the same cycle, their records share one captured timestamp and enter the FIFO one per cycle, lowest slice first.

Top module: `edge_stamp_engine`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A change on an enabled line produces one FIFO record. While that record is at the head:
  - offset 0x0C bits 23:16 read the slice number;
  - offset 0x14 reads the slice's previous value and offset 0x10 its current value, both with disabled lines forced to 0;
  - offsets 0x04 and 0x08 read the upper and lower 32 bits of the timestamp.
- R3: A change on a line whose enable bit is 0 creates no record. That line reads 0 in the value fields of later records.
- R4: When several slices change in the same cycle, each yields one record. The records enter in ascending slice order and carry the same timestamp.
- R5: The timestamp counts clock cycles. The difference between the timestamps of two line-driven records equals the number of cycles between the two input changes.
- R6: Status register (0x20) bits 15:8 give the FIFO occupancy. Writing a value with bit 0 set to the command register (0x1C) removes the head record and lowers the occupancy by one.
- R7: With the FIFO empty, the timestamp, source and value registers read 0.
- R8: Records that arrive while the FIFO is full are dropped and set a sticky overflow flag in status bit 0. Writing a value with bit 0 set to the status register clears the flag.
- R9: `irq` is high exactly while control bit 0 (engine on) and bit 1 (interrupt on) are both set and occupancy is at least the threshold held in control bits 15:8.
- R10: With control bit 0 clear, line changes create no records. Turning the engine back on produces no record for changes made while it was off.
- R11: The line-enable register of slice N sits at offset 0x40 + 0x20*N, and bit b enables line N*32+b. The register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timestamp tick |
| rst_n | input | 1 | Active-low reset |
| lines_in | input | NSLICE*32 | Monitored lines, line N*32+b on bit N*32+b |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives random toggles across all slices, rewrites the enable masks, and compares every drained record against a model queue.

Several corner cases are targeted directly:
- **Simultaneous changes in all three slices.** A design that reordered the slices, or stamped them at different cycles, would fail the slice and timestamp comparisons.
- **Toggles on disabled lines, and toggles made while the engine is off.** A leaky mask or a stale stored value would show up as extra records.
- **Twenty events into a sixteen-deep FIFO.** An engine that overwrote the oldest entry or missed the sticky flag would be caught here.
- **Reads of an empty FIFO and interrupt thresholds crossed in both directions.** These expose off-by-one occupancy compares.

// File: rtl/est_pkg.sv
package est_pkg;
   localparam int unsigned TS_W  = 64;
   localparam int unsigned SID_W = 8;
   localparam int unsigned LW    = 32;

   typedef struct packed {
      logic [TS_W-1:0]  ts;
      logic [SID_W-1:0] sid;
      logic [LW-1:0]    prev;
      logic [LW-1:0]    cur;
   } est_entry_t;

   localparam int unsigned ENTRY_W = $bits(est_entry_t);
endpackage

// File: rtl/est_sync.sv
module est_sync #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/est_detect.sv
module est_detect
   import est_pkg::*;
#(
   parameter int unsigned NSLICE = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [NSLICE*LW-1:0] lines,
   input  logic [NSLICE*LW-1:0] en_mask,
   input  logic [TS_W-1:0]      ts_now,
   output logic                 push_vld,
   output est_entry_t           push_entry
);
   localparam int unsigned IDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1;

   logic [LW-1:0]   prev_raw  [NSLICE];
   logic [LW-1:0]   snap_prev [NSLICE];
   logic [LW-1:0]   snap_cur  [NSLICE];
   logic [NSLICE-1:0] chg, pend;
   logic [TS_W-1:0] snap_ts;
   logic [IDX_W-1:0] sel;

   for (genvar gs = 0; gs < NSLICE; gs++) begin : g_cmp
      assign chg[gs] = |((lines[gs*LW +: LW] ^ prev_raw[gs]) & en_mask[gs*LW +: LW]);
   end

   always_comb begin
      sel = '0;
      for (int s = NSLICE - 1; s >= 0; s--)
         if (pend[s]) sel = IDX_W'(s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= '0;
         snap_ts <= '0;
         for (int s = 0; s < NSLICE; s++) begin
            prev_raw[s]  <= '0;
            snap_prev[s] <= '0;
            snap_cur[s]  <= '0;
         end
      end else if (!run) begin
         pend <= '0;
         for (int s = 0; s < NSLICE; s++) prev_raw[s] <= lines[s*LW +: LW];
      end else if (pend == '0) begin
         if (|chg) begin
            pend    <= chg;
            snap_ts <= ts_now;
            for (int s = 0; s < NSLICE; s++) begin
               if (chg[s]) begin
                  snap_prev[s] <= prev_raw[s] & en_mask[s*LW +: LW];
                  snap_cur[s]  <= lines[s*LW +: LW] & en_mask[s*LW +: LW];
                  prev_raw[s]  <= lines[s*LW +: LW];
               end
            end
         end
      end else begin
         pend[sel] <= 1'b0;
      end
   end

   assign push_vld        = |pend;
   assign push_entry.ts   = snap_ts;
   assign push_entry.sid  = SID_W'(sel);
   assign push_entry.prev = snap_prev[sel];
   assign push_entry.cur  = snap_cur[sel];

   // R4
   drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && |pend) |=> ($countones(pend) == $countones($past(pend)) - 1));
endmodule

// File: rtl/est_fifo.sv
module est_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         full,
   output logic                         empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
         cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   // R8
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R6
   fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/edge_stamp_engine.sv
module edge_stamp_engine
   import est_pkg::*;
#(
   parameter int unsigned NSLICE = 3,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSLICE*LW-1:0] lines_in,
   input  logic                 reg_wen,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 irq
);
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1);
   localparam int unsigned EN_BASE   = 'h40;
   localparam int unsigned EN_STRIDE = 'h20;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
   localparam logic [ADDR_W-1:0] A_TSH  = ADDR_W'('h04);
   localparam logic [ADDR_W-1:0] A_TSL  = ADDR_W'('h08);
   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'('h0C);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'('h10);
   localparam logic [ADDR_W-1:0] A_PRV  = ADDR_W'('h14);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h1C);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h20);

   if (NSLICE < 1 || NSLICE > 256) begin : g_bad_slices
      $error("NSLICE must be 1..256");
   end
   if (DEPTH < 2 || CNT_W > 8) begin : g_bad_depth
      $error("DEPTH must be 2..255");
   end
   if (EN_BASE + EN_STRIDE * NSLICE > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for NSLICE enable registers");
   end

   logic              ctrl_on, ctrl_ie, ovf;
   logic [7:0]        thr;
   logic [LW-1:0]     en_reg [NSLICE];
   logic [NSLICE*LW-1:0] en_flat, lines_s;
   logic [NSLICE-1:0] en_hit;
   logic [TS_W-1:0]   tick;
   logic              det_push, fifo_full, fifo_empty, pop_req;
   est_entry_t        det_entry, head;
   logic [ENTRY_W-1:0] head_raw;
   logic [CNT_W-1:0]  occ;
   logic [7:0]        occ8;

   est_sync #(.W(NSLICE*LW)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lines_in), .q(lines_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= '0;
      else        tick <= tick + 1'b1;
   end

   for (genvar gs = 0; gs < NSLICE; gs++) begin : g_en
      localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_BASE + EN_STRIDE * gs);
      assign en_hit[gs] = (reg_addr == A_EN);
      assign en_flat[gs*LW +: LW] = en_reg[gs];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     en_reg[gs] <= '0;
         else if (reg_wen && en_hit[gs]) en_reg[gs] <= reg_wdata;
      end
   end

   est_detect #(.NSLICE(NSLICE)) u_det (
      .clk(clk), .rst_n(rst_n), .run(ctrl_on), .lines(lines_s),
      .en_mask(en_flat), .ts_now(tick),
      .push_vld(det_push), .push_entry(det_entry));

   assign pop_req = reg_wen && (reg_addr == A_CMD) && reg_wdata[0];

   est_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(det_push), .din(det_entry),
      .pop(pop_req), .dout(head_raw), .cnt(occ),
      .full(fifo_full), .empty(fifo_empty));

   assign head = fifo_empty ? '0 : est_entry_t'(head_raw);
   assign occ8 = 8'(occ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_on <= 1'b0;
         ctrl_ie <= 1'b0;
         thr     <= '0;
         ovf     <= 1'b0;
      end else begin
         if (reg_wen && reg_addr == A_CTRL) begin
            ctrl_on <= reg_wdata[0];
            ctrl_ie <= reg_wdata[1];
            thr     <= reg_wdata[15:8];
         end
         if (det_push && fifo_full)
            ovf <= 1'b1;
         else if (reg_wen && reg_addr == A_STAT && reg_wdata[0])
            ovf <= 1'b0;
      end
   end

   assign irq = ctrl_on && ctrl_ie && (occ8 >= thr);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL: reg_rdata = {16'd0, thr, 6'd0, ctrl_ie, ctrl_on};
         A_TSH:  reg_rdata = head.ts[TS_W-1 -: 32];
         A_TSL:  reg_rdata = head.ts[31:0];
         A_SRC:  reg_rdata = {8'd0, head.sid, 16'd0};
         A_CUR:  reg_rdata = head.cur;
         A_PRV:  reg_rdata = head.prev;
         A_STAT: reg_rdata = {16'd0, occ8, 7'd0, ovf};
         default: begin
            for (int s = 0; s < NSLICE; s++)
               if (en_hit[s]) reg_rdata = en_reg[s];
         end
      endcase
   end

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(reg_wen && reg_addr == A_STAT && reg_wdata[0])) |=> ovf);
   // R10
   off_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_on |=> !det_push);
endmodule

// File: tb/edge_stamp_engine_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_engine_tb_top;
   localparam int NS = 3, DEPTH = 16, AW = 12;

   logic clk = 0, rst_n = 0;
   logic [NS*32-1:0] lines_in = '0;
   logic reg_wen = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic irq;

   edge_stamp_engine #(.NSLICE(NS), .DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_wen(reg_wen),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   always #4 clk = ~clk;

   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [31:0] raw [NS], en_m [NS], prv [NS];
   bit geng = 0, ie = 0, ovf_m = 0;
   int thr = 0;
   int q_sl[$];
   logic [31:0] q_pv[$], q_cv[$];
   longint q_cy[$];
   bit q_tok[$];
   longint k_off; bit k_known = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wen = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic model(input longint c, input bit tok);
      for (int s = 0; s < NS; s++) begin
         if (!geng) prv[s] = raw[s];
         else if (((raw[s] ^ prv[s]) & en_m[s]) != 0) begin
            if (q_sl.size() < DEPTH) begin
               q_sl.push_back(s); q_pv.push_back(prv[s] & en_m[s]);
               q_cv.push_back(raw[s] & en_m[s]); q_cy.push_back(c); q_tok.push_back(tok);
            end else ovf_m = 1;
            prv[s] = raw[s];
         end
      end
   endtask

   task automatic chk_irq(input string tag);
      #1 chk(tag, irq, geng && ie && (q_sl.size() >= thr));
   endtask

   task automatic drive(); // apply raw[] to pins, update model
      longint c;
      @(negedge clk);
      for (int s = 0; s < NS; s++) lines_in[s*32 +: 32] = raw[s];
      c = cyc;
      model(c, 1);
      repeat (8) @(negedge clk);
      chk_irq("R9 irq after event");
   endtask

   task automatic set_en(input int s, input logic [31:0] v);
      logic [31:0] r;
      wr(AW'(32'h40 + 32 * s), v);
      en_m[s] = v;
      model(0, 0);
      repeat (8) @(negedge clk);
      rd(AW'(32'h40 + 32 * s), r);
      chk("R11 enable readback", r, v);
   endtask

   task automatic set_ctrl(input bit on, input bit ien, input int th);
      wr(AW'(0), {16'd0, 8'(th), 6'd0, ien, on});
      geng = on; ie = ien; thr = th;
      if (!on) for (int s = 0; s < NS; s++) prv[s] = raw[s];
      repeat (4) @(negedge clk);
      chk_irq("R9 irq after ctrl write");
   endtask

   task automatic drain();
      logic [31:0] st, th_, tl, sr, cv, pv;
      logic [63:0] ts;
      rd(AW'('h20), st);
      chk("R6 occupancy", st[15:8], q_sl.size());
      chk("R8 overflow flag", st[0], ovf_m);
      while (q_sl.size() > 0) begin
         rd(AW'('h04), th_); rd(AW'('h08), tl); rd(AW'('h0C), sr);
         rd(AW'('h10), cv); rd(AW'('h14), pv);
         ts = {th_, tl};
         chk("R4 slice order", sr[23:16], q_sl[0]);
         chk("R2 current value", cv, q_cv[0]);
         chk("R2 previous value", pv, q_pv[0]);
         if (q_tok[0]) begin
            if (!k_known) begin k_off = longint'(ts) - q_cy[0]; k_known = 1; end
            else chk("R5 R4 timestamp", ts, 64'(q_cy[0] + k_off));
         end
         chk_irq("R9 irq before pop");
         wr(AW'('h1C), 32'h1);
         void'(q_sl.pop_front()); void'(q_pv.pop_front()); void'(q_cv.pop_front());
         void'(q_cy.pop_front()); void'(q_tok.pop_front());
         rd(AW'('h20), st);
         chk("R6 occupancy after pop", st[15:8], q_sl.size());
      end
      rd(AW'('h10), cv); chk("R7 empty current", cv, 0);
      rd(AW'('h08), tl); chk("R7 empty ts low", tl, 0);
      rd(AW'('h0C), sr); chk("R7 empty source", sr, 0);
      chk_irq("R9 irq empty");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] r;
      int cnt;
      void'($urandom(32'h5EED_1234));
      for (int s = 0; s < NS; s++) begin raw[s] = 0; en_m[s] = 0; prv[s] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(AW'('h00), r); chk("R1 ctrl reset", r, 0);
      rd(AW'('h20), r); chk("R1 status reset", r, 0);
      rd(AW'('h40), r); chk("R1 enable reset", r, 0);
      rd(AW'('h04), r); chk("R1 ts high reset", r, 0);
      #1 chk("R1 irq reset", irq, 0);

      set_ctrl(1, 1, 2);
      set_en(0, 32'hFFFF_FFFF);
      set_en(1, 32'h0000_FFFF);
      set_en(2, 32'hFFFF_FFFF);

      // R2 single line
      raw[0] = 32'h0000_0008; drive();
      // R3 disabled line only
      raw[1] = 32'h0010_0000; drive();
      rd(AW'('h20), r); chk("R3 no record for disabled line", r[15:8], q_sl.size());
      // R4 three slices at once
      raw[0] = 32'hA5A5_0000; raw[1] = 32'h0010_0003; raw[2] = 32'h8000_0001; drive();
      drain();

      // R10 engine off
      set_ctrl(0, 1, 1);
      raw[0] = 32'h1234_5678; raw[2] = 32'h0; drive();
      rd(AW'('h20), r); chk("R10 no record while off", r[15:8], 0);
      set_ctrl(1, 1, 1);
      repeat (6) @(negedge clk);
      rd(AW'('h20), r); chk("R10 no record on re-enable", r[15:8], 0);

      // R8 overflow
      for (int i = 0; i < 20; i++) begin raw[2] = raw[2] ^ 32'h1; drive(); end
      rd(AW'('h20), r);
      chk("R8 full count", r[15:8], DEPTH);
      chk("R8 sticky flag", r[0], 1);
      drain();
      rd(AW'('h20), r); chk("R8 flag holds after drain", r[0], 1);
      wr(AW'('h20), 32'h1); ovf_m = 0;
      rd(AW'('h20), r); chk("R8 flag cleared", r[0], 0);

      // random phase
      for (int it = 0; it < 90; it++) begin
         cnt = $urandom % 8;
         if (cnt == 0) set_en($urandom % NS, $urandom);
         else if (cnt == 1) set_ctrl(1, 1, $urandom % 5);
         else begin
            for (int s = 0; s < NS; s++)
               if ($urandom % 2) raw[s] = raw[s] ^ (($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : $urandom);
            drive();
         end
         if (q_sl.size() >= 10) drain();
      end
      drain();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule